// File: doc/BRIEF.md
# Quiet-Noisy Low-Power Scan Chain

This block is a scan chain made of dual-path scan cells. Each cell stores one bit in a master latch stage and a slave latch stage. Each stage is modelled as a storage element that updates on one clock edge. The master stage updates on the rising edge and the slave stage on the falling edge. A second wire, the jump path, links the master stage of each cell to the slave stage of the next cell. Alongside it, the usual scan path links each slave stage to the next master stage. A quiet control decides how the cells behave while the scan enable is high.

- **Quiet shift** (quiet high): the chain takes in one scan bit on every clock edge, so it moves two bits per clock period. Every functional data output is held at zero during this mode. The logic downstream therefore sees no toggling while a pattern is loaded.
- **Noisy shift** (quiet low): the chain behaves as an ordinary multiplexed scan chain. It shifts one bit per clock, and the functional outputs follow the stored bits.
- **Capture** (scan enable low): every cell captures its functional input, as a rising-edge flip-flop would.

A delay test uses the modes in this order. A pattern is first loaded quietly. Releasing quiet then shows that pattern at once. One noisy shift cycle follows and launches a second pattern. A capture cycle then records the response of the logic under test. The chain length must be even, and elaboration stops with an error otherwise.

Top module: `qn_scan_chain`

## Requirements
- R1: With scan_en low and quiet low, func_d sampled at a rising clock edge appears on func_q once the following falling edge has passed. The mapping is bit for bit (func_q[j] = func_d[j]).
- R2: While quiet is high, func_q is all zeros in every mode.
- R3: In quiet shift (scan_en high, quiet high), scan_in is taken in on every edge, rising and falling. The count starts at a rising edge. After NUM_CELLS edges, cell j holds the bit presented at edge NUM_CELLS-j (edges numbered from 1). Cell 0 is nearest scan_in. Sending P[NUM_CELLS-1] first and P[0] last therefore stores P with cell j = P[j].
- R4: In quiet shift, scan_out shows the last cell's slave stage while clk is low and its master stage while clk is high. A previously stored pattern P therefore leaves MSB first, one bit per half period, while the next pattern is loaded. P[NUM_CELLS-1] is visible before the first edge of the load, and P[NUM_CELLS-1-k] is visible after edge k.
- R5: In noisy shift (scan_en high, quiet low), scan_in is sampled at the rising edge. After the following falling edge, func_q equals {old func_q[NUM_CELLS-2:0], scan_in}.
- R6: When quiet falls, func_q shows the stored bits without any clock edge.
- R7: While quiet is low, scan_out equals the last cell's stored bit, func_q[NUM_CELLS-1].
- R8: A capture with scan_en low and quiet high still stores func_d, while func_q is held at zero. Releasing quiet afterwards shows the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the master stages update on the rising edge, the slave stages on the falling edge |
| scan_en | input | 1 | High selects scan shifting, low selects functional capture |
| quiet | input | 1 | High selects two-bit-per-clock shifting and forces func_q to zero |
| func_d | input | NUM_CELLS | Functional data inputs, one per cell |
| scan_in | input | 1 | Serial input of the chain, feeding both the scan path and the jump path of cell 0 |
| func_q | output | NUM_CELLS | Functional data outputs, zero while quiet is high |
| scan_out | output | 1 | Serial output of the chain, phase-selected during quiet shift |

## Verification
During a quiet shift, one edge both takes a new bit of the next pattern into cell 0 and moves an old bit of the stored pattern to scan_out through the jump path or the scan path. The bench provokes this by loading a second pattern directly on top of a first one. After every edge it compares scan_out with the MSB-first order of the first pattern. Releasing quiet then shows the second pattern on func_q, which confirms that unloading and loading did not disturb each other. The quiet release and the first noisy shift are judged the same way: func_q is sampled right after the release, with no edge in between, and again after one full clock.

// File: rtl/qn_scan_pkg.sv
package qn_scan_pkg;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'd0,
        MODE_NOISY   = 2'd1,
        MODE_QUIET   = 2'd2
    } shift_mode_e;

    typedef struct packed {
        logic mst;
        logic slv;
    } stage_next_t;

    function automatic shift_mode_e decode_mode(input logic scan_en, input logic quiet);
        if (!scan_en) begin
            return MODE_CAPTURE;
        end else if (quiet) begin
            return MODE_QUIET;
        end
        return MODE_NOISY;
    endfunction

endpackage

// File: rtl/qn_scan_cell.sv
module qn_scan_cell
    import qn_scan_pkg::*;
(
    input  logic clk,
    input  logic scan_en,
    input  logic quiet,
    input  logic d_in,
    input  logic sc_in,
    input  logic jmp_in,
    output logic d_out,
    output logic sc_out,
    output logic jmp_out
);

    shift_mode_e mode;
    stage_next_t stage_d;
    logic        mst_q;
    logic        slv_q;

    always_comb begin
        mode        = decode_mode(scan_en, quiet);
        stage_d.mst = (mode == MODE_CAPTURE) ? d_in : sc_in;
        stage_d.slv = (mode == MODE_QUIET) ? jmp_in : mst_q;
    end

    // master stage closes on the rising edge
    always_ff @(posedge clk) begin
        mst_q <= stage_d.mst;
    end

    // slave stage closes on the falling edge
    always_ff @(negedge clk) begin
        slv_q <= stage_d.slv;
    end

    assign jmp_out = mst_q;
    assign sc_out  = slv_q;
    // NOR gating: low whenever quiet is high, the stored bit is untouched
    assign d_out   = ~(~slv_q | quiet);

endmodule

// File: rtl/qn_scan_outsel.sv
module qn_scan_outsel (
    input  logic clk,
    input  logic scan_en,
    input  logic quiet,
    input  logic last_sc,
    input  logic last_jmp,
    output logic chain_out
);

    logic jump_phase;

    always_comb begin
        jump_phase = scan_en & quiet & clk;
        chain_out  = jump_phase ? last_jmp : last_sc;
    end

endmodule

// File: rtl/qn_scan_chain.sv
module qn_scan_chain #(
    parameter int NUM_CELLS = 8
) (
    input  logic                 clk,
    input  logic                 scan_en,
    input  logic                 quiet,
    input  logic [NUM_CELLS-1:0] func_d,
    input  logic                 scan_in,
    output logic [NUM_CELLS-1:0] func_q,
    output logic                 scan_out
);

    localparam int LAST = NUM_CELLS - 1;

    if ((NUM_CELLS % 2) != 0 || NUM_CELLS < 2) begin : g_len_check
        $error("qn_scan_chain: NUM_CELLS must be even and at least 2");
    end

    logic [NUM_CELLS-1:0] sc_link;
    logic [NUM_CELLS-1:0] jmp_link;

    for (genvar j = 0; j < NUM_CELLS; j++) begin : g_cell
        logic sc_src;
        logic jmp_src;
        if (j == 0) begin : g_head
            assign sc_src  = scan_in;
            assign jmp_src = scan_in;
        end else begin : g_body
            assign sc_src  = sc_link[j-1];
            assign jmp_src = jmp_link[j-1];
        end
        qn_scan_cell u_cell (
            .clk     (clk),
            .scan_en (scan_en),
            .quiet   (quiet),
            .d_in    (func_d[j]),
            .sc_in   (sc_src),
            .jmp_in  (jmp_src),
            .d_out   (func_q[j]),
            .sc_out  (sc_link[j]),
            .jmp_out (jmp_link[j])
        );
    end

    qn_scan_outsel u_outsel (
        .clk       (clk),
        .scan_en   (scan_en),
        .quiet     (quiet),
        .last_sc   (sc_link[LAST]),
        .last_jmp  (jmp_link[LAST]),
        .chain_out (scan_out)
    );

endmodule

// File: rtl/qn_scan_chain_chk.sv
module qn_scan_chain_chk #(
    parameter int NUM_CELLS = 8
) (
    input logic                 clk,
    input logic                 scan_en,
    input logic                 quiet,
    input logic [NUM_CELLS-1:0] func_d,
    input logic                 scan_in,
    input logic [NUM_CELLS-1:0] func_q,
    input logic                 scan_out
);

    logic [1:0]           warm_q   = '0;
    logic                 cap_ok_q = 1'b0;
    logic                 cap_ok2_q = 1'b0;
    logic [NUM_CELLS-1:0] cap_d_q  = '0;
    logic                 nsy_ok_q = 1'b0;
    logic                 nsy_ok2_q = 1'b0;
    logic [NUM_CELLS-1:0] nsy_q_q  = '0;
    logic                 nsy_in_q = 1'b0;

    always_ff @(posedge clk) begin
        if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        cap_ok_q <= !scan_en && !quiet;
        cap_d_q  <= func_d;
        nsy_ok_q <= scan_en && !quiet;
        nsy_q_q  <= func_q;
        nsy_in_q <= scan_in;
    end

    always_ff @(negedge clk) begin
        cap_ok2_q <= cap_ok_q && !scan_en && !quiet;
        nsy_ok2_q <= nsy_ok_q && scan_en && !quiet;
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (warm_q < 2'd2)
        (cap_ok2_q && !quiet) |-> (func_q == cap_d_q));

    p_quiet_zero_r2: assert property (@(negedge clk) disable iff (warm_q < 2'd2)
        quiet |-> ($countones(func_q) == 0));

    p_noisy_shift_r5: assert property (@(posedge clk) disable iff (warm_q < 2'd2)
        (nsy_ok2_q && !quiet) |-> (func_q == {nsy_q_q[NUM_CELLS-2:0], nsy_in_q}));

    p_serial_out_r7: assert property (@(posedge clk) disable iff (warm_q < 2'd2)
        !quiet |-> (scan_out == func_q[NUM_CELLS-1]));

endmodule

bind qn_scan_chain qn_scan_chain_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
    .clk      (clk),
    .scan_en  (scan_en),
    .quiet    (quiet),
    .func_d   (func_d),
    .scan_in  (scan_in),
    .func_q   (func_q),
    .scan_out (scan_out)
);

// File: tb/qn_scan_chain_tb.sv
module qn_scan_chain_tb;

    localparam int N        = 8;
    localparam int HALF_PER = 5;
    localparam int NVEC     = 6;

    // row: {quiet, func_d, expected func_q}
    localparam logic [2*N:0] VEC [NVEC] = '{
        {1'b0, 8'hA5, 8'hA5},
        {1'b0, 8'h00, 8'h00},
        {1'b1, 8'hFF, 8'h00},
        {1'b0, 8'h3C, 8'h3C},
        {1'b1, 8'h81, 8'h00},
        {1'b0, 8'hFF, 8'hFF}
    };

    logic         clk = 1'b0;
    logic         scan_en = 1'b0;
    logic         quiet = 1'b1;
    logic [N-1:0] func_d = '0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_q;
    logic         scan_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    qn_scan_chain #(.NUM_CELLS(N)) u_dut (
        .clk      (clk),
        .scan_en  (scan_en),
        .quiet    (quiet),
        .func_d   (func_d),
        .scan_in  (scan_in),
        .func_q   (func_q),
        .scan_out (scan_out)
    );

    always #HALF_PER clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // wait for the next edge of either kind, settle mid-phase
    task automatic edge_step();
        @(clk);
        #2;
    endtask

    // quiet load of pattern p, MSB first; records outgoing bits
    task automatic quiet_load(input logic [N-1:0] p, output logic [N-1:0] unl);
        unl[N-1] = scan_out;
        for (int k = 0; k < N; k++) begin
            scan_in = p[N-1-k];
            edge_step();
            if (k < N - 1) unl[N-2-k] = scan_out;
            check("R2", func_q, '0);
        end
    endtask

    logic [N-1:0] unl;
    logic [N-1:0] pat_a;
    logic [N-1:0] pat_b;

    initial begin
        #2;
        // reset state: quiet high holds outputs low
        check("R2 reset", func_q, '0);

        // table of capture vectors (R1, R2)
        for (int v = 0; v < NVEC; v++) begin
            scan_en = 1'b0;
            quiet   = VEC[v][2*N];
            func_d  = VEC[v][2*N-1:N];
            edge_step();
            edge_step();
            check(quiet ? "R2 table" : "R1 table", func_q, VEC[v][N-1:0]);
        end

        // R8: capture while quiet, then release
        quiet  = 1'b1;
        func_d = 8'h6E;
        edge_step();
        edge_step();
        check("R8 masked", func_q, '0);
        func_d = 8'h00;
        quiet  = 1'b0;
        #1;
        check("R8 released", func_q, 8'h6E);
        #(-0);

        // quiet load of pattern A (R3)
        edge_step();
        edge_step();
        scan_en = 1'b1;
        quiet   = 1'b1;
        pat_a   = 8'hB4;
        quiet_load(pat_a, unl);
        quiet = 1'b0;
        #1;
        check("R6 release", func_q, pat_a);
        check("R3 load A", func_q, pat_a);
        check("R7 scan_out", {7'd0, scan_out}, {7'd0, pat_a[N-1]});

        // second quiet load on top of A: unload order (R4) and load (R3)
        quiet = 1'b1;
        #1;
        check("R2 requiet", func_q, '0);
        pat_b = 8'h59;
        quiet_load(pat_b, unl);
        check("R4 unload", unl, pat_a);
        quiet = 1'b0;
        #1;
        check("R3 load B", func_q, pat_b);
        check("R6 instant", func_q, pat_b);

        // noisy shifts (R5, R7)
        scan_in = 1'b1;
        edge_step();
        edge_step();
        check("R5 shift1", func_q, {pat_b[N-2:0], 1'b1});
        check("R7 noisy", {7'd0, scan_out}, {7'd0, pat_b[N-2]});
        scan_in = 1'b0;
        edge_step();
        edge_step();
        check("R5 shift2", func_q, {pat_b[N-3:0], 2'b10});

        // R4 again: unload a known all-ones/zero edge pattern
        quiet = 1'b1;
        pat_a = 8'h0F;
        quiet_load(pat_a, unl);
        check("R4 unload shifted", unl, {pat_b[N-3:0], 2'b10});
        quiet = 1'b0;
        #1;
        check("R3 load C", func_q, pat_a);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule